// File: doc/BRIEF.md
# Prioritized Vectoring Interrupt Controller

This block gathers up to 64 edge-triggered interrupt sources and presents them to a processor on two request lines: a fast class and a normal class. A rising edge on a source input latches a pending bit. The bit goes into the fast-class or the normal-class pending word, chosen by the source's 3-bit priority at the moment of the edge. Per-source enable bits mask pending bits before they reach the request lines and the arbiter. Software clears a pending bit by writing a one to it.

For the normal class, a combinational arbiter selects the enabled pending source with the smallest priority value. When several sources share that value, the lowest index wins. A readable entry word returns a programmable base plus four times (winner index + 1). Software derives the source number from that value. All configuration goes through a single-cycle 32-bit register port: address, write strobe, write data and combinational read data.

Top module: `vec_intc`

## Requirements
- R1: After reset, every pending, enable, priority, control and base register reads zero, the entry word (0x14) reads zero, and both request outputs are low.
- R2: A 0-to-1 transition on `srcIn[i]` sets pending bit i. The bit goes to the fast pending word if the source's priority is 0 or 1, and to the normal pending word if the priority is 2 to 7. A level held high does not set the bit again after it has been cleared.
- R3: Writing a pending word (fast 0x00/0x04, normal 0x08/0x0C) clears each bit written as 1 and leaves each bit written as 0 unchanged. If a rising edge on a source arrives in the same cycle as the clearing write to its bit, the bit stays set.
- R4: Enable words 0x18/0x1C hold one unmask bit per source. A cleared bit removes the source from the request outputs and from arbitration from the next cycle on, while its pending bit is kept.
- R5: In each pair of pending or enable words, bit n of the lower address refers to source n, and bit n of the upper address refers to source 32+n.
- R6: Priority word 0x30+4j holds sources 8j..8j+7. Source 8j+k sits in bits [4k+2:4k], and bit 4k+3 always reads zero.
- R7: `fiqReq` is high while any enabled fast-pending bit is set, and `irqReq` is high while any enabled normal-pending bit is set.
- R8: The entry word (0x14) reads base + 4*(w+1). Here w is the enabled normal-pending source with the smallest priority value, with the lowest index winning a tie. It reads the base alone when `irqReq` is low.
- R9: The control word (0x20) and the entry base word (0x24) read back the full 32-bit value last written.
- R10: Addresses outside the map, and addresses not aligned to a word, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | NUM_SRC | Interrupt source inputs, rising-edge sensitive |
| regAddr | input | ADDR_W | Register byte address |
| regWr | input | 1 | Write strobe, captured at the clock edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data |
| fiqReq | output | 1 | Fast-class request |
| irqReq | output | 1 | Normal-class request |

## Verification
The bench builds the block with its defaults: 64 sources, an 8-bit address and two fast priority levels. These values bring the upper source group, all eight priority words and both request classes within reach. With them the bench can exercise winners in either group, ties that cross the group boundary, and a fast-class source that must stay out of the entry word.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

  localparam int MAX_GRP  = 2;
  localparam int MAX_PREG = 8;
  localparam int PRIO_W   = 3;

  // word indices (byte address / 4)
  localparam int W_FIQ0  = 0;
  localparam int W_IRQ0  = 2;
  localparam int W_ENTRY = 5;
  localparam int W_EN0   = 6;
  localparam int W_CTL   = 8;
  localparam int W_BASE  = 9;
  localparam int W_PRIO0 = 12;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_FIQP, SEL_IRQP, SEL_ENTRY, SEL_EN, SEL_CTL, SEL_BASE, SEL_PRIO
  } rdSel_e;

  typedef struct packed {
    logic [MAX_GRP-1:0]  ackFiq;
    logic [MAX_GRP-1:0]  ackIrq;
    logic [MAX_GRP-1:0]  setEn;
    logic                setCtl;
    logic                setBase;
    logic [MAX_PREG-1:0] setPrio;
    rdSel_e              rdSel;
    logic [2:0]          rdIdx;
  } strobe_t;

endpackage

// File: rtl/vec_intc_decode.sv
module vec_intc_decode
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  output strobe_t           strb
);
  localparam int NGRP  = NUM_SRC / 32;
  localparam int NPREG = NUM_SRC / 8;

  int unsigned wordIdx;
  logic aligned;

  always_comb begin
    wordIdx = int'(regAddr[ADDR_W-1:2]);
    aligned = (regAddr[1:0] == 2'b00);
    strb = '0;
    strb.rdSel = SEL_NONE;
    if (aligned) begin
      if (wordIdx < W_FIQ0 + NGRP) begin
        strb.rdSel = SEL_FIQP;
        strb.rdIdx = 3'(wordIdx - W_FIQ0);
        strb.ackFiq[wordIdx - W_FIQ0] = regWr;
      end else if (wordIdx >= W_IRQ0 && wordIdx < W_IRQ0 + NGRP) begin
        strb.rdSel = SEL_IRQP;
        strb.rdIdx = 3'(wordIdx - W_IRQ0);
        strb.ackIrq[wordIdx - W_IRQ0] = regWr;
      end else if (wordIdx == W_ENTRY) begin
        strb.rdSel = SEL_ENTRY;
      end else if (wordIdx >= W_EN0 && wordIdx < W_EN0 + NGRP) begin
        strb.rdSel = SEL_EN;
        strb.rdIdx = 3'(wordIdx - W_EN0);
        strb.setEn[wordIdx - W_EN0] = regWr;
      end else if (wordIdx == W_CTL) begin
        strb.rdSel = SEL_CTL;
        strb.setCtl = regWr;
      end else if (wordIdx == W_BASE) begin
        strb.rdSel = SEL_BASE;
        strb.setBase = regWr;
      end else if (wordIdx >= W_PRIO0 && wordIdx < W_PRIO0 + NPREG) begin
        strb.rdSel = SEL_PRIO;
        strb.rdIdx = 3'(wordIdx - W_PRIO0);
        strb.setPrio[wordIdx - W_PRIO0] = regWr;
      end
    end
  end

endmodule

// File: rtl/vec_intc_core.sv
module vec_intc_core
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int FIQ_LEVELS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [31:0]        wrData,
  input  strobe_t            strb,
  output logic [31:0]        rdData,
  output logic               fiqReq,
  output logic               irqReq
);
  localparam int NGRP  = NUM_SRC / 32;
  localparam int NPREG = NUM_SRC / 8;
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int PIX_W = $clog2(NPREG);

  logic [NUM_SRC-1:0]             prevIn;
  logic [NUM_SRC-1:0]             edgeVec;
  logic [NUM_SRC-1:0]             toFiq;
  logic [NGRP-1:0][31:0]          edgeGrp, fiqGrp, fiqPend, irqPend, enGrp;
  logic [NUM_SRC-1:0]             fiqFlat, irqFlat, enFlat;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioTab;
  logic [NPREG-1:0][31:0]         prioWord;
  logic [31:0]                    ctlReg, baseReg, entryVal;
  logic                           winFound;
  logic [IDX_W-1:0]               winIdx;
  logic [PRIO_W-1:0]              winPrio;

  assign edgeVec = srcIn & ~prevIn;
  assign edgeGrp = edgeVec;
  assign fiqFlat = fiqPend;
  assign irqFlat = irqPend;
  assign enFlat  = enGrp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= srcIn;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cls
    assign toFiq[i] = (prioTab[i] < PRIO_W'(FIQ_LEVELS));
  end
  assign fiqGrp = toFiq;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fiqPend[g] <= '0;
        irqPend[g] <= '0;
        enGrp[g]   <= '0;
      end else begin
        fiqPend[g] <= (fiqPend[g] & ~(strb.ackFiq[g] ? wrData : 32'h0))
                    | (edgeGrp[g] & fiqGrp[g]);
        irqPend[g] <= (irqPend[g] & ~(strb.ackIrq[g] ? wrData : 32'h0))
                    | (edgeGrp[g] & ~fiqGrp[g]);
        if (strb.setEn[g]) enGrp[g] <= wrData;
      end
    end
  end

  for (genvar j = 0; j < NPREG; j++) begin : g_preg
    for (genvar k = 0; k < 8; k++) begin : g_nib
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              prioTab[j*8+k] <= '0;
        else if (strb.setPrio[j]) prioTab[j*8+k] <= wrData[4*k +: PRIO_W];
      end
      assign prioWord[j][4*k +: 4] = {{(4-PRIO_W){1'b0}}, prioTab[j*8+k]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg  <= '0;
      baseReg <= '0;
    end else begin
      if (strb.setCtl)  ctlReg  <= wrData;
      if (strb.setBase) baseReg <= wrData;
    end
  end

  // normal-class arbiter: strict compare keeps the lowest index on ties
  always_comb begin
    winFound = 1'b0;
    winIdx   = '0;
    winPrio  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (irqFlat[i] && enFlat[i] && (!winFound || prioTab[i] < winPrio)) begin
        winFound = 1'b1;
        winIdx   = IDX_W'(i);
        winPrio  = prioTab[i];
      end
    end
  end

  assign entryVal = winFound ? baseReg + ((32'(winIdx) + 32'd1) << 2) : baseReg;
  assign fiqReq   = |(fiqFlat & enFlat);
  assign irqReq   = |(irqFlat & enFlat);

  always_comb begin
    case (strb.rdSel)
      SEL_FIQP:  rdData = fiqPend[strb.rdIdx[GRP_W-1:0]];
      SEL_IRQP:  rdData = irqPend[strb.rdIdx[GRP_W-1:0]];
      SEL_EN:    rdData = enGrp[strb.rdIdx[GRP_W-1:0]];
      SEL_ENTRY: rdData = entryVal;
      SEL_CTL:   rdData = ctlReg;
      SEL_BASE:  rdData = baseReg;
      SEL_PRIO:  rdData = prioWord[strb.rdIdx[PIX_W-1:0]];
      default:   rdData = '0;
    endcase
  end

  // R2
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeVec != '0) |=> (((fiqFlat | irqFlat) & $past(edgeVec)) == $past(edgeVec)));

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackIrq[0] && wrData == '1 && edgeGrp[0] == '0) |=> (irqPend[0] == '0));

  // R4
  mask_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setEn[0] && wrData == '0) |=> ((irqPend[0] & enGrp[0]) == '0));

  // R8
  entry_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (entryVal != baseReg));

  // R8
  entry_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (entryVal == baseReg));

  // R6
  always_comb begin
    if (rstN && strb.rdSel == SEL_PRIO)
      prio_rsvd_chk: assert ((rdData & 32'h8888_8888) == 32'h0);
  end

endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int ADDR_W     = 8,
  parameter int FIQ_LEVELS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic               fiqReq,
  output logic               irqReq
);
  strobe_t strb;

  vec_intc_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uDecode (
    .regAddr (regAddr),
    .regWr   (regWr),
    .strb    (strb)
  );

  vec_intc_core #(.NUM_SRC(NUM_SRC), .FIQ_LEVELS(FIQ_LEVELS)) uCore (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .wrData  (regWdata),
    .strb    (strb),
    .rdData  (regRdata),
    .fiqReq  (fiqReq),
    .irqReq  (irqReq)
  );

endmodule

// File: tb/sim_vec_intc.sv
module sim_vec_intc;
  localparam int NSRC = 64;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] src;
  logic [7:0]  addr;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        fiq, irq;
  int nChk = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  vec_intc #(.NUM_SRC(NSRC)) u0 (
    .clk(clk), .rstN(rstN), .srcIn(src), .regAddr(addr), .regWr(wr),
    .regWdata(wdata), .regRdata(rdata), .fiqReq(fiq), .irqReq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic regCheck(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic outCheck(string tag, logic expFiq, logic expIrq);
    @(negedge clk); #1;
    chk(tag, {30'b0, fiq, irq}, {30'b0, expFiq, expIrq});
  endtask

  task automatic pulse(int i);
    @(negedge clk); src[i] = 1'b1;
    @(negedge clk); src[i] = 1'b0;
  endtask

  task automatic t_reset();
    regCheck("R1 fast pending", 8'h00, 32'h0);
    regCheck("R1 normal pending", 8'h0C, 32'h0);
    regCheck("R1 enable", 8'h18, 32'h0);
    regCheck("R1 entry", 8'h14, 32'h0);
    regCheck("R1 priority", 8'h4C, 32'h0);
    outCheck("R1 outputs", 1'b0, 1'b0);
  endtask

  task automatic t_prio();
    regWrite(8'h30, 32'hFFFF_FFFF);
    regCheck("R6 reserved bits", 8'h30, 32'h7777_7777);
    regWrite(8'h4C, 32'h1234_5670);
    regCheck("R6 field packing", 8'h4C, 32'h1234_5670);
    for (int j = 0; j < 8; j++) regWrite(8'(8'h30 + 4*j), 32'h2222_2222);
    regCheck("R6 last word", 8'h4C, 32'h2222_2222);
  endtask

  task automatic t_edge();
    @(negedge clk); src[5] = 1'b1;
    @(negedge clk);
    regCheck("R2 edge latched", 8'h08, 32'h20);
    outCheck("R4 masked source", 1'b0, 1'b0);
    regWrite(8'h18, 32'h20);
    outCheck("R7 normal request", 1'b0, 1'b1);
    regCheck("R8 entry single", 8'h14, 32'd24);
    regWrite(8'h08, 32'h0);
    regCheck("R3 zero bits untouched", 8'h08, 32'h20);
    regWrite(8'h08, 32'h20);
    regCheck("R2 held level not relatched", 8'h08, 32'h0);
    outCheck("R7 request drops", 1'b0, 1'b0);
    @(negedge clk); src[5] = 1'b0;
  endtask

  task automatic t_group();
    pulse(40);
    regCheck("R5 upper pending word", 8'h0C, 32'h100);
    regCheck("R5 lower pending word", 8'h08, 32'h0);
    regWrite(8'h1C, 32'h100);
    regCheck("R5 upper enable word", 8'h1C, 32'h100);
    regCheck("R8 entry upper group", 8'h14, 32'd164);
  endtask

  task automatic t_arb();
    regWrite(8'h24, 32'h1000);
    regCheck("R9 base readback", 8'h24, 32'h1000);
    regWrite(8'h30, 32'h2222_5222);
    regWrite(8'h34, 32'h2222_2322);
    regWrite(8'h44, 32'h2222_2223);
    pulse(3);
    pulse(10);
    regWrite(8'h18, 32'h408);
    regCheck("R8 tie lowest index", 8'h14, 32'h102C);
    regWrite(8'h44, 32'h2222_2222);
    regCheck("R8 smaller value wins", 8'h14, 32'h10A4);
    regWrite(8'h18, 32'h0);
    regCheck("R4 pending kept when masked", 8'h08, 32'h408);
    regWrite(8'h44, 32'h2222_2227);
    regWrite(8'h18, 32'h8);
    regCheck("R4 masked source out of arbitration", 8'h14, 32'h1010);
    regWrite(8'h08, 32'hFFFF_FFFF);
    regWrite(8'h0C, 32'hFFFF_FFFF);
    regCheck("R3 clear all", 8'h0C, 32'h0);
    outCheck("R7 idle", 1'b0, 1'b0);
    regCheck("R8 entry idle is base", 8'h14, 32'h1000);
  endtask

  task automatic t_fiq();
    regWrite(8'h38, 32'h2221_2222);
    pulse(20);
    regCheck("R2 fast class latched", 8'h00, 32'h0010_0000);
    regCheck("R2 not in normal word", 8'h08, 32'h0);
    regWrite(8'h18, 32'h0010_0000);
    outCheck("R7 fast request", 1'b1, 1'b0);
    regCheck("R8 fast source excluded", 8'h14, 32'h1000);
    regWrite(8'h00, 32'hFFFF_FFFF);
    outCheck("R3 fast cleared", 1'b0, 1'b0);
  endtask

  task automatic t_collide();
    regWrite(8'h18, 32'h80);
    pulse(7);
    outCheck("R7 before collision", 1'b0, 1'b1);
    @(negedge clk); addr = 8'h08; wdata = 32'h80; wr = 1'b1; src[7] = 1'b1;
    @(negedge clk); wr = 1'b0; src[7] = 1'b0;
    regCheck("R3 edge wins over clear", 8'h08, 32'h80);
    regWrite(8'h08, 32'h80);
    regCheck("R3 plain clear", 8'h08, 32'h0);
  endtask

  task automatic t_misc();
    regWrite(8'h20, 32'hA5A5_0F0F);
    regCheck("R9 control readback", 8'h20, 32'hA5A5_0F0F);
    regWrite(8'h10, 32'hFFFF_FFFF);
    regWrite(8'h2C, 32'hFFFF_FFFF);
    regWrite(8'h19, 32'h0);
    regCheck("R10 hole reads zero", 8'h10, 32'h0);
    regCheck("R10 beyond map", 8'h50, 32'h0);
    regCheck("R10 unaligned write ignored", 8'h18, 32'h80);
    regCheck("R10 unaligned read zero", 8'h1A, 32'h0);
  endtask

  initial begin
    rstN = 1'b0; src = '0; addr = '0; wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_prio();
    t_edge();
    t_group();
    t_arb();
    t_fiq();
    t_collide();
    t_misc();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule